// File: doc/BRIEF.md
# Nested Boolean Logic Trigger Unit

The block watches four digitized logic channels, one sample per system clock, and turns Boolean conditions on them into a trigger. Two condition sets, A and B, are programmed through a small register write port. Either set can drive the trigger alone. In nested mode a hit on A arms the unit and a later hit on B fires it. The interval between arming and firing is exported as a gate, for time-interval or event-count measurement.

Three qualifiers act on the condition path. An external clock input can restrict condition sampling to that clock's rising edges. A programmable minimum-duration filter, set in system-clock cycles, drops short events. An inhibit input blocks triggering and disarms the unit. A front-panel output carries either the trigger pulse or the interval gate. A view output shows either the selected filtered condition or the external clock.

Register map (write only, 16-bit data). Address 0 holds set A and address 1 holds set B. In each condition word, bits [3:0] are the per-channel care mask, bits [7:4] the required level per channel, bit 8 the any-match bit (0 = AND, 1 = OR) and bit 9 the invert bit. Address 2 is the mode word. In it, bits [1:0] pick the source (0 = A, 1 = B, 2 or 3 = nested), bit 2 enables external-clock qualification, bit 3 puts the interval gate on the front-panel output, bit 4 puts the external clock on the view output, and bits [15:8] hold the filter length L. Address 3 is ignored.

Top module: `nested_trig_unit`

## Requirements
- R1: While reset is low, and after it is released, trigPulse, gateOut and trigOut are 0. Reset loads the condition words with care = 0, any-match = 1 and invert = 0, so each condition is false, and loads the mode word with 0.
- R2: A condition is true as follows. In AND mode, every channel with its care bit set equals its level bit; an empty mask gives true. In OR mode, at least one cared channel matches; an empty mask gives false. The result is then XORed with the invert bit. With L = 0 and no qualifier, viewOut shows the selected condition one clock after chIn is applied.
- R3: With L = 0 the trigger is a single-cycle trigPulse. It appears on the second rising clock edge after the condition becomes true and fires once per rising edge of the condition, however long the condition is held.
- R4: With source B, only condition B can trigger; condition A has no effect.
- R5: In nested mode, a rising edge of A arms the unit. Only a later rising edge of B fires it, and firing disarms it. A rise of A while B is already true arms the unit without firing it, and a rise of B while unarmed does nothing.
- R6: gateOut goes high on the clock edge after the one that sampled the rising edge of A. It goes low on the same edge on which trigPulse rises.
- R7: A condition has to stay true for more than L consecutive samples before it counts. A shorter event is dropped, and a dip restarts the count.
- R8: With external-clock qualification on, the conditions are resampled only when extClk is high and was low one system clock earlier. Between those edges the previous result is held.
- R9: While inhibitIn is high, no trigger is generated, and the armed state and gateOut are cleared.
- R10: trigOut carries gateOut when mode bit 3 is set and trigPulse otherwise.
- R11: viewOut equals extClk when mode bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chIn | input | 4 | Digitized logic channels |
| extClk | input | 1 | External qualifying clock |
| inhibitIn | input | 1 | Trigger inhibit, active high |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register address |
| cfgWrData | input | 16 | Register write data |
| trigPulse | output | 1 | Single-cycle trigger pulse |
| gateOut | output | 1 | A-then-B interval gate |
| trigOut | output | 1 | Front-panel output: pulse or gate |
| viewOut | output | 1 | Filtered condition or external clock |

## Verification
The bench sweeps every mask, level, combine mode and invert setting against all sixteen channel patterns. A decoder that treats an empty mask wrongly, or that mixes up level polarity, disagrees there. Nested sequences cover the case where B becomes true before A and the case where A rises while B is already high; a design that fires on B's level instead of its edge would trigger early. Pulse widths around each filter length from 0 to 4, plus a broken pulse, expose off-by-one errors and a counter that fails to restart. Inhibit is applied both while the unit is armed and while the condition rises, to catch a unit that forgets to disarm.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CH_N = 4;

  // condition word: care mask in the low bits, then levels, combine, invert
  typedef struct packed {
    logic            invert;
    logic            anyMode;
    logic [CH_N-1:0] level;
    logic [CH_N-1:0] care;
  } condCfg_t;

  localparam int COND_W = $bits(condCfg_t);

  typedef enum logic [1:0] {
    SRC_A     = 2'd0,
    SRC_B     = 2'd1,
    SRC_NEST  = 2'd2,
    SRC_NEST2 = 2'd3
  } srcSel_t;

  // strobes from datapath to control
  typedef struct packed {
    logic riseB;
    logic riseA;
  } condStrobe_t;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output condCfg_t          cfgA,
  output condCfg_t          cfgB,
  output srcSel_t           srcSel,
  output logic              extQual,
  output logic              outGate,
  output logic              viewClk,
  output logic [FILT_W-1:0] filtLen
);
  localparam int FILT_LSB = 8;
  localparam condCfg_t COND_RST = '{invert: 1'b0, anyMode: 1'b1,
                                    level: '0, care: '0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgA    <= COND_RST;
      cfgB    <= COND_RST;
      srcSel  <= SRC_A;
      extQual <= 1'b0;
      outGate <= 1'b0;
      viewClk <= 1'b0;
      filtLen <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        2'd0: cfgA <= condCfg_t'(cfgWrData[COND_W-1:0]);
        2'd1: cfgB <= condCfg_t'(cfgWrData[COND_W-1:0]);
        2'd2: begin
          srcSel  <= srcSel_t'(cfgWrData[1:0]);
          extQual <= cfgWrData[2];
          outGate <= cfgWrData[3];
          viewClk <= cfgWrData[4];
          filtLen <= cfgWrData[FILT_LSB +: FILT_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_N-1:0]   chIn,
  input  logic              extClk,
  input  condCfg_t          cfgA,
  input  condCfg_t          cfgB,
  input  logic              extQual,
  input  logic              viewClk,
  input  logic              viewB,
  input  logic [FILT_W-1:0] filtLen,
  output condStrobe_t       strobe,
  output logic              viewOut
);
  localparam int SETS = 2;

  logic extPrev;
  logic extEdge;
  logic [SETS-1:0] fltOk;
  logic [SETS-1:0] riseOk;

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extClk;
  end
  assign extEdge = extClk & ~extPrev;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    condCfg_t        cfg;
    logic [CH_N-1:0] hit;
    logic            rawCond;
    logic            heldQ;
    logic            fPrevQ;
    logic            fNow;
    logic [FILT_W-1:0] runCnt;

    assign cfg     = (g == 0) ? cfgA : cfgB;
    assign hit     = cfg.care & ~(chIn ^ cfg.level);
    assign rawCond = (cfg.anyMode ? (|hit) : (hit == cfg.care)) ^ cfg.invert;

    // sample point: every clock, or only on external clock rising edges
    always_ff @(posedge clk) begin
      if (!rstN)                   heldQ <= 1'b0;
      else if (!extQual || extEdge) heldQ <= rawCond;
    end

    // minimum-duration filter: counts samples the condition has stayed true
    always_ff @(posedge clk) begin
      if (!rstN || !heldQ)      runCnt <= '0;
      else if (runCnt < filtLen) runCnt <= runCnt + 1'b1;
    end

    assign fNow = heldQ && (runCnt >= filtLen);

    always_ff @(posedge clk) begin
      if (!rstN) fPrevQ <= 1'b0;
      else       fPrevQ <= fNow;
    end

    assign fltOk[g]  = fNow;
    assign riseOk[g] = fNow & ~fPrevQ;
  end

  assign strobe.riseA = riseOk[0];
  assign strobe.riseB = riseOk[1];
  assign viewOut = viewClk ? extClk : (viewB ? fltOk[1] : fltOk[0]);
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  condStrobe_t strobe,
  input  srcSel_t     srcSel,
  input  logic        inhibitIn,
  input  logic        outGate,
  output logic        trigPulse,
  output logic        gateOut,
  output logic        trigOut
);
  logic nested;
  logic armedQ;
  logic trigQ;
  logic fire;

  assign nested = srcSel[1];

  always_comb begin
    case (srcSel)
      SRC_A:   fire = strobe.riseA;
      SRC_B:   fire = strobe.riseB;
      default: fire = armedQ & strobe.riseB;
    endcase
    if (inhibitIn) fire = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      trigQ  <= 1'b0;
    end else begin
      trigQ <= fire;
      if (inhibitIn || !nested)      armedQ <= 1'b0;
      else if (armedQ)               armedQ <= ~strobe.riseB;
      else if (strobe.riseA)         armedQ <= 1'b1;
    end
  end

  assign trigPulse = trigQ;
  assign gateOut   = armedQ;
  assign trigOut   = outGate ? armedQ : trigQ;
endmodule

// File: rtl/nested_trig_unit.sv
module nested_trig_unit
  import trig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_N-1:0]   chIn,
  input  logic              extClk,
  input  logic              inhibitIn,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              trigPulse,
  output logic              gateOut,
  output logic              trigOut,
  output logic              viewOut
);
  condCfg_t          cfgA, cfgB;
  srcSel_t           srcSel;
  logic              extQual, outGate, viewClk;
  logic [FILT_W-1:0] filtLen;
  condStrobe_t       strobe;

  trig_cfg_regs #(.DATA_W(DATA_W), .FILT_W(FILT_W)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgA(cfgA), .cfgB(cfgB), .srcSel(srcSel),
    .extQual(extQual), .outGate(outGate), .viewClk(viewClk),
    .filtLen(filtLen)
  );

  trig_datapath #(.FILT_W(FILT_W)) u_dp (
    .clk(clk), .rstN(rstN), .chIn(chIn), .extClk(extClk),
    .cfgA(cfgA), .cfgB(cfgB), .extQual(extQual), .viewClk(viewClk),
    .viewB(srcSel != SRC_A), .filtLen(filtLen), .strobe(strobe),
    .viewOut(viewOut)
  );

  trig_control u_ctl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcSel(srcSel),
    .inhibitIn(inhibitIn), .outGate(outGate), .trigPulse(trigPulse),
    .gateOut(gateOut), .trigOut(trigOut)
  );
endmodule

// File: rtl/nested_trig_unit_checker.sv
module nested_trig_unit_checker (
  input logic clk,
  input logic rstN,
  input logic inhibitIn,
  input logic cfgWrEn,
  input logic trigPulse,
  input logic gateOut
);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  p_inhibit_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    inhibitIn |=> !trigPulse);

  p_inhibit_disarms_r9: assert property (@(posedge clk) disable iff (!rstN)
    inhibitIn |=> !gateOut);

  p_gate_close_fires_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateOut) && !$past(inhibitIn) && !$past(cfgWrEn)) |-> trigPulse);

  p_arm_no_fire_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> !trigPulse);
endmodule

bind nested_trig_unit nested_trig_unit_checker u_chk (
  .clk(clk), .rstN(rstN), .inhibitIn(inhibitIn), .cfgWrEn(cfgWrEn),
  .trigPulse(trigPulse), .gateOut(gateOut)
);

// File: tb/sim_nested_trig_unit.sv
module sim_nested_trig_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  chIn;
  logic        extClk, inhibitIn, cfgWrEn;
  logic [1:0]  cfgAddr;
  logic [15:0] cfgWrData;
  logic        trigPulse, gateOut, trigOut, viewOut;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nested_trig_unit u0 (
    .clk(clk), .rstN(rstN), .chIn(chIn), .extClk(extClk),
    .inhibitIn(inhibitIn), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .trigPulse(trigPulse), .gateOut(gateOut),
    .trigOut(trigOut), .viewOut(viewOut)
  );

  // count trigger pulses shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (rstN && trigPulse) pulseCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic [15:0] condWord(input logic [3:0] m, input logic [3:0] l,
                                           input bit orm, input bit inv);
    return {6'd0, inv, orm, l, m};
  endfunction

  function automatic logic [15:0] modeWord(input int src, input bit eq, input bit og,
                                           input bit vc, input int len);
    return 16'((len << 8) | (int'(vc) << 4) | (int'(og) << 3) | (int'(eq) << 2) | src);
  endfunction

  function automatic bit expCond(input logic [3:0] m, input logic [3:0] l,
                                 input bit orm, input bit inv, input logic [3:0] c);
    int nCare = 0;
    int nMatch = 0;
    bit r;
    for (int i = 0; i < 4; i++) begin
      if (m[i]) begin
        nCare++;
        if (c[i] == l[i]) nMatch++;
      end
    end
    r = orm ? (nMatch > 0) : (nMatch == nCare);
    return r ^ inv;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; chIn = 4'h0; extClk = 1'b0; inhibitIn = 1'b0;
    cfgWrEn = 1'b0; cfgAddr = 2'd0; cfgWrData = 16'h0;
    tick(3);
    // R1: outputs quiet during reset
    chk(trigPulse == 0, "R1 trigPulse in reset", trigPulse, 0);
    chk(gateOut == 0, "R1 gateOut in reset", gateOut, 0);
    chk(trigOut == 0, "R1 trigOut in reset", trigOut, 0);
    rstN = 1'b1;
    pulseCnt = 0;
    chIn = 4'hF; tick(3); chIn = 4'h0; tick(3);
    chk(pulseCnt == 0, "R1 default conditions false", pulseCnt, 0);
    chk(viewOut == 0, "R1 default view", viewOut, 0);

    // R2: exhaustive condition sweep, source A, no filter
    wr(2, modeWord(0, 0, 0, 0, 0));
    for (int m = 0; m < 16; m++)
      for (int l = 0; l < 16; l++)
        for (int o = 0; o < 2; o++)
          for (int v = 0; v < 2; v++) begin
            wr(0, condWord(4'(m), 4'(l), o[0], v[0]));
            for (int c = 0; c < 16; c++) begin
              bit e;
              chIn = 4'(c);
              tick(1);
              e = expCond(4'(m), 4'(l), o[0], v[0], 4'(c));
              chk(viewOut == e, "R2 condition value", viewOut, e);
            end
          end

    // R3: single pulse on rising edge, two edges of latency
    wr(0, condWord(4'h1, 4'h1, 0, 0));
    chIn = 4'h0; tick(4); pulseCnt = 0;
    chIn = 4'h1;
    tick(1); chk(trigPulse == 0, "R3 no pulse after one edge", trigPulse, 0);
    tick(1); chk(trigPulse == 1, "R3 pulse after two edges", trigPulse, 1);
    chk(trigOut == 1, "R10 trigOut carries pulse", trigOut, 1);
    tick(1); chk(trigPulse == 0, "R3 pulse one cycle", trigPulse, 0);
    tick(8); chk(pulseCnt == 1, "R3 one pulse per rise", pulseCnt, 1);

    // R4: source B only
    wr(1, condWord(4'h2, 4'h2, 0, 0));
    wr(2, modeWord(1, 0, 0, 0, 0));
    chIn = 4'h0; tick(4); pulseCnt = 0;
    chIn = 4'h1; tick(4);
    chk(pulseCnt == 0, "R4 A ignored with source B", pulseCnt, 0);
    chIn = 4'h3; tick(4);
    chk(pulseCnt == 1, "R4 B triggers", pulseCnt, 1);
    chk(viewOut == 1, "R4 view shows B", viewOut, 1);

    // R5/R6: nested A then B
    wr(2, modeWord(2, 0, 0, 0, 0));
    chIn = 4'h0; tick(4); pulseCnt = 0;
    chIn = 4'h1;
    tick(1); chk(gateOut == 0, "R6 gate not yet open", gateOut, 0);
    tick(1); chk(gateOut == 1, "R6 gate opens", gateOut, 1);
    tick(3);
    chk(gateOut == 1, "R5 stays armed", gateOut, 1);
    chk(pulseCnt == 0, "R5 A alone no trigger", pulseCnt, 0);
    chIn = 4'h3;
    tick(1); chk(gateOut == 1 && trigPulse == 0, "R6 gate before fire", gateOut, 1);
    tick(1);
    chk(trigPulse == 1, "R5 B fires", trigPulse, 1);
    chk(gateOut == 0, "R6 gate closes with pulse", gateOut, 0);
    tick(3); chk(pulseCnt == 1, "R5 single nested trigger", pulseCnt, 1);
    // B before A
    chIn = 4'h0; tick(4); pulseCnt = 0;
    chIn = 4'h2; tick(4);
    chk(pulseCnt == 0, "R5 B unarmed no trigger", pulseCnt, 0);
    chk(gateOut == 0, "R5 B unarmed no gate", gateOut, 0);
    chIn = 4'h3; tick(4);
    chk(gateOut == 1, "R5 A arms while B high", gateOut, 1);
    chk(pulseCnt == 0, "R5 B level does not fire", pulseCnt, 0);
    chIn = 4'h1; tick(3);
    chIn = 4'h3; tick(4);
    chk(pulseCnt == 1, "R5 later B edge fires", pulseCnt, 1);
    chk(gateOut == 0, "R5 disarmed after fire", gateOut, 0);

    // R10: gate on front-panel output
    wr(2, modeWord(2, 0, 1, 0, 0));
    chIn = 4'h0; tick(4); pulseCnt = 0;
    chIn = 4'h1; tick(3);
    chk(trigOut == 1, "R10 trigOut carries gate", trigOut, 1);
    chIn = 4'h3; tick(3);
    chk(trigOut == 0, "R10 gate closed on trigOut", trigOut, 0);
    chk(pulseCnt == 1, "R10 pulse still produced", pulseCnt, 1);

    // R9: inhibit disarms and blocks
    wr(2, modeWord(2, 0, 0, 0, 0));
    chIn = 4'h0; tick(4); pulseCnt = 0;
    chIn = 4'h1; tick(3);
    chk(gateOut == 1, "R9 armed before inhibit", gateOut, 1);
    inhibitIn = 1'b1; tick(1);
    chk(gateOut == 0, "R9 inhibit clears gate", gateOut, 0);
    inhibitIn = 1'b0;
    chIn = 4'h3; tick(4);
    chk(pulseCnt == 0, "R9 disarmed B no trigger", pulseCnt, 0);
    wr(2, modeWord(0, 0, 0, 0, 0));
    chIn = 4'h0; tick(4); pulseCnt = 0;
    inhibitIn = 1'b1;
    chIn = 4'h1; tick(5);
    chk(pulseCnt == 0, "R9 inhibit blocks trigger", pulseCnt, 0);
    inhibitIn = 1'b0; tick(3);
    chk(pulseCnt == 0, "R9 no late trigger", pulseCnt, 0);
    chIn = 4'h0; tick(3); chIn = 4'h1; tick(3);
    chk(pulseCnt == 1, "R9 triggers after release", pulseCnt, 1);

    // R7: filter sweep
    for (int len = 0; len <= 4; len++)
      for (int n = 1; n <= 6; n++) begin
        int e;
        wr(2, modeWord(0, 0, 0, 0, len));
        chIn = 4'h0; tick(len + 3); pulseCnt = 0;
        chIn = 4'h1; tick(n);
        chIn = 4'h0; tick(len + 4);
        e = (n > len) ? 1 : 0;
        chk(pulseCnt == e, "R7 filter length", pulseCnt, e);
      end
    wr(2, modeWord(0, 0, 0, 0, 3));
    chIn = 4'h0; tick(6); pulseCnt = 0;
    chIn = 4'h1; tick(3); chIn = 4'h0; tick(1);
    chIn = 4'h1; tick(3); chIn = 4'h0; tick(8);
    chk(pulseCnt == 0, "R7 dip restarts count", pulseCnt, 0);

    // R8: external clock qualification
    wr(2, modeWord(0, 1, 0, 0, 0));
    extClk = 1'b0; chIn = 4'h0; tick(2);
    extClk = 1'b1; tick(1); extClk = 1'b0; tick(2);
    pulseCnt = 0;
    chIn = 4'h1; tick(5);
    chk(pulseCnt == 0, "R8 no edge no sample", pulseCnt, 0);
    extClk = 1'b1; tick(4);
    chk(pulseCnt == 1, "R8 sampled on ext edge", pulseCnt, 1);
    extClk = 1'b0; chIn = 4'h0; tick(3);
    chk(viewOut == 1, "R8 held between edges", viewOut, 1);

    // R11: view shows external clock
    wr(2, modeWord(0, 0, 0, 1, 0));
    extClk = 1'b1; #1;
    chk(viewOut == 1, "R11 view follows extClk high", viewOut, 1);
    extClk = 1'b0; #1;
    chk(viewOut == 0, "R11 view follows extClk low", viewOut, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule